// File: doc/BRIEF.md
# Dual-Port Parallel Transfer Splitter

This block connects one logical memory transfer to two physical memory ports, A and B. A transfer is opened with a one-cycle `start` pulse. The pulse carries the transfer settings: the mode (individual or parallel), the selected port for individual mode, and the data byte count. After that, the upstream side sends a byte stream. Each byte carries a phase tag that says whether it is command, address, mode, size or data.

In individual mode, every byte goes to the selected port and every read byte comes from that port. In parallel mode, both devices run the same transfer at the same time:

- Command, address, mode and size bytes are copied unchanged to both ports.
- Write data bytes are split between the ports. Even-numbered bytes go to A and odd-numbered bytes go to B.
- Read data is merged back into the original byte order by taking A and B in turn.

A parallel transfer with an odd byte count is refused.

All byte interfaces use valid/ready. A byte moves only in a cycle where both valid and ready are high. A downstream port's `ready` must not depend on its `valid`. When a byte goes to both ports, it is offered to the two ports only in a cycle where both are ready, so both take it at the same edge. Back-pressure from any target port holds `s_ready` low, and the upstream byte then stays in place. Port completion is reported with the plain pulses `done_a` and `done_b`.

Top module: `dual_port_splitter`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `s_ready`, `a_valid`, `b_valid` and `r_valid` are 0. A `start` pulse with an accepted setting raises `busy` at the next clock edge. `s_ready` is 0 whenever `busy` is 0.
- R2: In individual mode (`start_par`=0), every upstream byte goes only to the port chosen by `start_port`, where 0 selects A and 1 selects B. The other port's `valid` stays 0.
- R3: In parallel mode, bytes with phase code 0 (command), 1 (address), 2 (mode) or 3 (size) are offered to both ports with the same byte and phase. Each such byte is consumed once, in a single cycle where both ports are ready.
- R4: In parallel mode, data bytes (phase code 4) go alternately to the two ports. The count starts from the first data byte of the transfer. Even-indexed bytes go to port A and odd-indexed bytes go to port B, and no data byte is offered to both ports.
- R5: In parallel mode, read bytes on `r_*` are taken alternately from port A and port B, starting with A, so that the original byte order is rebuilt.
- R6: In individual mode, read bytes come only from the selected port. The ready of the other read port stays 0.
- R7: A `start` with `start_par`=1 and an odd `start_len` gives a one-cycle `err` pulse at the next edge. `busy` stays 0 and no byte is accepted.
- R8: A parallel transfer ends only after both `done_a` and `done_b` have been seen, in either order or cycle. An individual transfer ends on the selected port's done pulse. At the end, `done` pulses for one cycle and `busy` falls at the same edge.
- R9: When a target port is not ready, `s_ready` is 0 and no port completes a handshake. The byte is neither lost nor duplicated.
- R10: `start` is ignored while `busy` is 1. The routing of the ongoing transfer does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Open a transfer (one-cycle pulse) |
| start_par | input | 1 | 1 = parallel mode, 0 = individual mode |
| start_port | input | 1 | Individual-mode port: 0 = A, 1 = B |
| start_len | input | LEN_W | Data byte count of the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| s_valid | input | 1 | Upstream byte valid |
| s_ready | output | 1 | Upstream byte accepted |
| s_phase | input | 3 | Upstream phase code (0 cmd, 1 addr, 2 mode, 3 size, 4 data) |
| s_byte | input | BYTE_W | Upstream byte |
| a_valid | output | 1 | Port A byte valid |
| a_ready | input | 1 | Port A ready |
| a_phase | output | 3 | Port A phase code |
| a_byte | output | BYTE_W | Port A byte |
| b_valid | output | 1 | Port B byte valid |
| b_ready | input | 1 | Port B ready |
| b_phase | output | 3 | Port B phase code |
| b_byte | output | BYTE_W | Port B byte |
| ra_valid | input | 1 | Port A read byte valid |
| ra_ready | output | 1 | Port A read byte taken |
| ra_byte | input | BYTE_W | Port A read byte |
| rb_valid | input | 1 | Port B read byte valid |
| rb_ready | output | 1 | Port B read byte taken |
| rb_byte | input | BYTE_W | Port B read byte |
| r_valid | output | 1 | Merged read byte valid |
| r_ready | input | 1 | Merged read byte accepted |
| r_byte | output | BYTE_W | Merged read byte |
| done_a | input | 1 | Port A completion pulse |
| done_b | input | 1 | Port B completion pulse |

## Verification
The assertions check these properties on every cycle:

- The unselected port stays silent in individual mode.
- A byte offered to both ports is always identical and never a data byte.
- A parallel data byte never reaches both ports.
- A stalled upstream byte never completes a half handshake.
- The two read ports are never drained together.
- `done` and `err` appear only as the transfer leaves, or never enters, the busy state.

Only the bench scenarios can show the actual byte order: the even/odd split of write data, the A-then-B rebuild of read data, and the need for both completion pulses in either order. The same holds for refusing an odd-length parallel transfer and for ignoring `start` during a transfer.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int PH_W = 3;
  typedef enum logic [PH_W-1:0] {
    PH_CMD  = 3'd0,
    PH_ADDR = 3'd1,
    PH_MODE = 3'd2,
    PH_SIZE = 3'd3,
    PH_DATA = 3'd4
  } phase_e;
endpackage

// File: rtl/dps_ctrl.sv
module dps_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_par,
  input  logic             start_port,
  input  logic [LEN_W-1:0] start_len,
  input  logic             done_a,
  input  logic             done_b,
  output logic             busy,
  output logic             par,
  output logic             port,
  output logic             done,
  output logic             err
);
  logic seen_a, seen_b, fin, odd_reject;

  assign odd_reject = start_par & start_len[0];
  assign fin = par ? ((seen_a | done_a) & (seen_b | done_b))
                   : (port ? done_b : done_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      par    <= 1'b0;
      port   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      seen_a <= 1'b0;
      seen_b <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (odd_reject) begin
            err <= 1'b1;
          end else begin
            busy   <= 1'b1;
            par    <= start_par;
            port   <= start_port;
            seen_a <= 1'b0;
            seen_b <= 1'b0;
          end
        end
      end else if (fin) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        seen_a <= seen_a | done_a;
        seen_b <= seen_b | done_b;
      end
    end
  end

  // R8: completion only closes an open transfer
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R7: a rejection never opens a transfer
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  // R8: parallel transfer closes only once both ports reported
  a_r8_both_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && par && !(seen_a || done_a)) |=> busy);
endmodule

// File: rtl/dps_tx_route.sv
module dps_tx_route
  import dps_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              par,
  input  logic              port,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PH_W-1:0]   s_phase,
  input  logic [BYTE_W-1:0] s_byte,
  output logic              a_valid,
  input  logic              a_ready,
  output logic [PH_W-1:0]   a_phase,
  output logic [BYTE_W-1:0] a_byte,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [PH_W-1:0]   b_phase,
  output logic [BYTE_W-1:0] b_byte
);
  logic is_data, wtog, want_a, want_b;

  assign is_data = (s_phase == PH_DATA);
  assign want_a  = busy & (par ? (~is_data | ~wtog) : ~port);
  assign want_b  = busy & (par ? (~is_data |  wtog) :  port);

  assign a_valid = s_valid & want_a & (~want_b | b_ready);
  assign b_valid = s_valid & want_b & (~want_a | a_ready);
  assign s_ready = (want_a | want_b) & (~want_a | a_ready) & (~want_b | b_ready);

  assign a_phase = s_phase;
  assign b_phase = s_phase;
  assign a_byte  = s_byte;
  assign b_byte  = s_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     wtog <= 1'b0;
    else if (!busy)                                 wtog <= 1'b0;
    else if (s_valid && s_ready && par && is_data)  wtog <= ~wtog;
  end

  // R2: individual mode keeps the other port silent
  a_r2_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !par && !port) |-> !b_valid);
  a_r2_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !par && port) |-> !a_valid);
  // R3: a byte on both ports is identical and never payload
  a_r3_same_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid) |-> (a_byte == b_byte && a_phase == b_phase && a_phase != PH_DATA));
  // R4: parallel payload goes to exactly one port
  a_r4_data_single: assert property (@(posedge clk) disable iff (!rst_n)
    (par && s_valid && is_data && busy) |-> !(a_valid && b_valid));
  // R9: a stalled upstream byte completes no port handshake
  a_r9_no_half: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |-> !(a_valid && a_ready) && !(b_valid && b_ready));
endmodule

// File: rtl/dps_rx_merge.sv
module dps_rx_merge #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              par,
  input  logic              port,
  input  logic              ra_valid,
  output logic              ra_ready,
  input  logic [BYTE_W-1:0] ra_byte,
  input  logic              rb_valid,
  output logic              rb_ready,
  input  logic [BYTE_W-1:0] rb_byte,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [BYTE_W-1:0] r_byte
);
  logic rtog, from_b;

  assign from_b   = par ? rtog : port;
  assign r_valid  = busy & (from_b ? rb_valid : ra_valid);
  assign r_byte   = from_b ? rb_byte : ra_byte;
  assign ra_ready = busy & ~from_b & r_ready;
  assign rb_ready = busy &  from_b & r_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            rtog <= 1'b0;
    else if (!busy)                        rtog <= 1'b0;
    else if (par && r_valid && r_ready)    rtog <= ~rtog;
  end

  // R6: never drain both read ports together
  a_r6_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(ra_ready && rb_ready));
  // R5: merged read output exists only inside a transfer
  a_r5_read_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> busy);
endmodule

// File: rtl/dual_port_splitter.sv
module dual_port_splitter
  import dps_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_par,
  input  logic              start_port,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [2:0]        s_phase,
  input  logic [BYTE_W-1:0] s_byte,
  output logic              a_valid,
  input  logic              a_ready,
  output logic [2:0]        a_phase,
  output logic [BYTE_W-1:0] a_byte,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [2:0]        b_phase,
  output logic [BYTE_W-1:0] b_byte,
  input  logic              ra_valid,
  output logic              ra_ready,
  input  logic [BYTE_W-1:0] ra_byte,
  input  logic              rb_valid,
  output logic              rb_ready,
  input  logic [BYTE_W-1:0] rb_byte,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [BYTE_W-1:0] r_byte,
  input  logic              done_a,
  input  logic              done_b
);
  logic par, port;

  dps_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_par(start_par),
    .start_port(start_port), .start_len(start_len), .done_a(done_a),
    .done_b(done_b), .busy(busy), .par(par), .port(port), .done(done), .err(err)
  );

  dps_tx_route #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .busy(busy), .par(par), .port(port),
    .s_valid(s_valid), .s_ready(s_ready), .s_phase(s_phase), .s_byte(s_byte),
    .a_valid(a_valid), .a_ready(a_ready), .a_phase(a_phase), .a_byte(a_byte),
    .b_valid(b_valid), .b_ready(b_ready), .b_phase(b_phase), .b_byte(b_byte)
  );

  dps_rx_merge #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .busy(busy), .par(par), .port(port),
    .ra_valid(ra_valid), .ra_ready(ra_ready), .ra_byte(ra_byte),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_byte(rb_byte),
    .r_valid(r_valid), .r_ready(r_ready), .r_byte(r_byte)
  );

  // R1: nothing is accepted outside a transfer
  a_r1_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!s_ready && !a_valid && !b_valid && !r_valid));
  // R10: a start during a transfer does not end it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done_a && !done_b) |=> busy);
endmodule

// File: tb/sim_dual_port_splitter.sv
module sim_dual_port_splitter;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, start_par = 0, start_port = 0;
  logic [15:0] start_len = '0;
  logic busy, done, err;
  logic s_valid = 0, s_ready;
  logic [2:0] s_phase = '0;
  logic [7:0] s_byte = '0;
  logic a_valid, a_ready = 1, b_valid, b_ready = 1;
  logic [2:0] a_phase, b_phase;
  logic [7:0] a_byte, b_byte;
  logic ra_valid = 0, rb_valid = 0, ra_ready, rb_ready;
  logic [7:0] ra_byte = '0, rb_byte = '0;
  logic r_valid, r_ready = 0;
  logic [7:0] r_byte;
  logic done_a = 0, done_b = 0;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_port_splitter u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic open_xfer(input logic par, input logic prt, input int len);
    @(negedge clk);
    start = 1; start_par = par; start_port = prt; start_len = 16'(len);
    @(negedge clk);
    start = 0;
  endtask

  task automatic put(input string req, input int ph, input int byt, input logic ea, input logic eb);
    @(negedge clk);
    s_valid = 1; s_phase = 3'(ph); s_byte = 8'(byt);
    #1;
    check({req, " a_valid"}, a_valid, ea);
    check({req, " b_valid"}, b_valid, eb);
    if (ea) check({req, " a_byte"}, a_byte, byt);
    if (eb) check({req, " b_byte"}, b_byte, byt);
    @(posedge clk); #1;
    s_valid = 0;
  endtask

  task automatic pulse_done(input logic da, input logic db);
    @(negedge clk);
    done_a = da; done_b = db;
    @(negedge clk);
    done_a = 0; done_b = 0;
  endtask

  task automatic t_reset;
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);
    check("R1 err after reset", err, 0);
    check("R1 s_ready idle", s_ready, 0);
    check("R1 r_valid idle", r_valid, 0);
  endtask

  task automatic t_indiv_b;
    open_xfer(0, 1, 2);
    check("R1 busy after start", busy, 1);
    put("R2 cmd", 0, 8'h0B, 0, 1);
    put("R2 data0", 4, 8'h51, 0, 1);
    put("R2 data1", 4, 8'h52, 0, 1);
    pulse_done(1, 0);
    check("R8 individual B ignores done_a", busy, 1);
    pulse_done(0, 1);
    check("R8 individual done", done, 1);
    check("R8 busy drops", busy, 0);
  endtask

  task automatic t_par_write;
    open_xfer(1, 0, 4);
    b_ready = 0;
    @(negedge clk);
    s_valid = 1; s_phase = 3'd0; s_byte = 8'h38;
    #1;
    check("R9 s_ready stalled", s_ready, 0);
    check("R9 a_valid held", a_valid, 0);
    @(posedge clk); #1;
    b_ready = 1; s_valid = 0;
    put("R3 cmd copy", 0, 8'h38, 1, 1);
    put("R3 addr copy", 1, 8'h12, 1, 1);
    put("R3 size copy", 3, 8'h04, 1, 1);
    put("R4 data0 to A", 4, 8'h11, 1, 0);
    put("R4 data1 to B", 4, 8'h22, 0, 1);
    put("R4 data2 to A", 4, 8'h33, 1, 0);
    put("R4 data3 to B", 4, 8'h44, 0, 1);
    pulse_done(0, 1);
    check("R8 waits for A", busy, 1);
    check("R8 no early done", done, 0);
    pulse_done(1, 0);
    check("R8 parallel done", done, 1);
  endtask

  task automatic t_par_read;
    open_xfer(1, 0, 4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ra_valid = 1; rb_valid = 1; r_ready = 1;
      ra_byte = 8'(8'hA0 + i); rb_byte = 8'(8'hB0 + i);
      #1;
      check("R5 merged valid", r_valid, 1);
      check("R5 merged order", r_byte, (i % 2 == 0) ? (8'hA0 + i) : (8'hB0 + i));
      @(posedge clk); #1;
    end
    ra_valid = 0; rb_valid = 0; r_ready = 0;
    pulse_done(1, 1);
    check("R8 both same cycle", done, 1);
  endtask

  task automatic t_indiv_read_a;
    open_xfer(0, 0, 2);
    @(negedge clk);
    ra_valid = 1; rb_valid = 1; r_ready = 1; ra_byte = 8'h5A; rb_byte = 8'hC3;
    #1;
    check("R6 byte from A", r_byte, 8'h5A);
    check("R6 B read ready low", rb_ready, 0);
    @(posedge clk); #1;
    #1;
    check("R6 still from A", r_byte, 8'h5A);
    ra_valid = 0; rb_valid = 0; r_ready = 0;
    // R10: start during transfer asks for port B; routing stays on A
    open_xfer(0, 1, 2);
    put("R10 routing unchanged", 0, 8'h9F, 1, 0);
    pulse_done(1, 0);
    check("R10 ended on port A done", done, 1);
  endtask

  task automatic t_odd_reject;
    @(negedge clk);
    start = 1; start_par = 1; start_len = 16'd3;
    @(negedge clk);
    start = 0;
    check("R7 err pulse", err, 1);
    check("R7 stays idle", busy, 0);
    @(negedge clk);
    s_valid = 1; s_phase = 3'd0; s_byte = 8'h01;
    #1;
    check("R7 no byte accepted", s_ready, 0);
    check("R7 err one cycle", err, 0);
    @(posedge clk); #1;
    s_valid = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_indiv_b();
    t_par_write();
    t_par_read();
    t_indiv_read_a();
    t_odd_reject();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule